// File: doc/BRIEF.md
# Control Transfer Timeout Monitor

This block follows a USB control transfer through its phases and checks each phase against its own time budget. It sees three kinds of one-cycle event pulses from the endpoint logic: a SETUP packet has arrived (with a flag saying whether a data stage follows), a data packet has completed (with a flag marking the final packet), and the status stage has completed. Time is measured in milliseconds. A prescaler counts system clocks, with the number of clocks per millisecond set by a parameter, so a bench can shorten a millisecond to a few cycles.

A request without a data stage has 2 ms to finish its status stage. A request with a data stage has 10 ms for its first data packet, 5 ms between each later packet and the packet before it, and 2 ms for the status stage after the final packet. When a budget runs out, the monitor stops tracking the transfer and raises a sticky timeout flag. The flag carries a 2-bit code naming the phase that overran. Software clears the flag by writing a one. A new SETUP at any moment drops whatever was being tracked and starts again. How the device then answers the host is decided elsewhere.

Top module: `ctl_xfer_watchdog`

## Requirements
- R1: After reset, timeout_flag is 0, timeout_phase is 0 and tracking is 0.
- R2: A setup_pulse in any state, including mid-transfer, makes tracking 1 on the next cycle. It discards the previous phase and its elapsed time, and starts the first-data budget (setup_with_data=1) or the no-data budget (setup_with_data=0) from zero.
- R3: For a request without a data stage, a status_pulse within NODATA_MS milliseconds ends tracking. If none arrives, the flag is set with phase code 0.
- R4: For a request with a data stage, the first data_pulse must come within FIRST_MS milliseconds of the SETUP. Otherwise the flag is set with phase code 1.
- R5: Each later data_pulse must come within NEXT_MS milliseconds of the previous data_pulse. Otherwise the flag is set with phase code 2.
- R6: A data_pulse with data_is_last=1 ends the data stage. A status_pulse must then come within STATUS_MS milliseconds, or the flag is set with phase code 3.
- R7: A budget of L ms equals L*CLK_PER_MS clock edges counted from the edge that sampled the starting event. An event sampled on that last edge is in time. Without one, timeout_flag reads 1 just after that edge and 0 just after the edge before it.
- R8: A timeout ends tracking (tracking=0). A data_pulse or status_pulse while not tracking has no effect. A status_pulse during the data stage has no effect and leaves the running budget unchanged.
- R9: While set, timeout_flag stays 1 and timeout_phase keeps the code of the first failure, even if later transfers also time out.
- R10: A write with ack_wr=1 and ack_wdata=1 clears timeout_flag and timeout_phase on the next cycle. A write with ack_wdata=0 changes neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_pulse | input | 1 | One-cycle pulse: SETUP packet received |
| setup_with_data | input | 1 | With setup_pulse: request has a data stage |
| data_pulse | input | 1 | One-cycle pulse: data packet completed |
| data_is_last | input | 1 | With data_pulse: this packet ends the data stage |
| status_pulse | input | 1 | One-cycle pulse: status stage completed |
| ack_wr | input | 1 | Write strobe of the write-one-to-clear flag register |
| ack_wdata | input | 1 | Write data; 1 clears the flag |
| timeout_flag | output | 1 | Sticky: a phase overran its budget |
| timeout_phase | output | 2 | Failing phase: 0 no-data status, 1 first data, 2 later data, 3 status after data |
| tracking | output | 1 | A transfer is being timed |

## Verification
A table of transfers is run through the monitor: no-data requests, and data-stage requests with one to three packets. Each transfer either finishes exactly on its budget edge or overruns one chosen phase. This separates the four budgets and the four phase codes, and shows that each budget restarts at each packet. Directed cases cover the rest. A second SETUP arrives partway through a data-stage budget and must replace it with the shorter no-data budget. A status pulse arrives during the data stage and must not disturb the first-data budget. Stray pulses arrive while idle. A second failure must not overwrite the first code, and a write of zero must leave the flag alone.

// File: rtl/ctw_pkg.sv
package ctw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_NODATA = 3'd1,
        ST_FIRST  = 3'd2,
        ST_NEXT   = 3'd3,
        ST_STATUS = 3'd4
    } ctw_state_e;

    typedef enum logic [1:0] {
        PH_NODATA = 2'd0,
        PH_FIRST  = 2'd1,
        PH_NEXT   = 2'd2,
        PH_STATUS = 2'd3
    } ctw_phase_e;

    typedef struct packed {
        logic setup;
        logic has_data;
        logic data;
        logic last;
        logic status;
    } ctw_evt_t;

    typedef struct packed {
        logic       valid;
        ctw_phase_e phase;
    } ctw_fail_t;

    // Phase code reported for a state; idle maps to code 0 (timer not running)
    function automatic ctw_phase_e phase_of(ctw_state_e s);
        case (s)
            ST_FIRST:  return PH_FIRST;
            ST_NEXT:   return PH_NEXT;
            ST_STATUS: return PH_STATUS;
            default:   return PH_NODATA;
        endcase
    endfunction

endpackage

// File: rtl/ctw_ms_timer.sv
module ctw_ms_timer #(
    parameter int CLK_PER_MS = 50000,
    parameter int MS_W       = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            restart,
    input  logic [MS_W-1:0] limit_ms,
    output logic            expire
);
    localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CLK_PER_MS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic             tick;

    assign tick = (pre_q == PRE_TOP);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (tick) begin
            pre_q <= '0;
            ms_q  <= ms_q + MS_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // Budget spent on the tick that completes the last millisecond
    assign expire = run && tick && (ms_q == limit_ms - MS_W'(1));

endmodule

// File: rtl/ctw_phase_fsm.sv
module ctw_phase_fsm
    import ctw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctw_evt_t   evt,
    input  logic       expire,
    output ctw_state_e state,
    output logic       restart,
    output ctw_fail_t  fail
);
    ctw_state_e nxt;

    always_comb begin
        nxt     = state;
        restart = 1'b0;
        fail    = '0;
        if (evt.setup) begin
            nxt     = evt.has_data ? ST_FIRST : ST_NODATA;
            restart = 1'b1;
        end else begin
            case (state)
                ST_NODATA, ST_STATUS: begin
                    if (evt.status) begin
                        nxt = ST_IDLE;
                    end else if (expire) begin
                        nxt        = ST_IDLE;
                        fail.valid = 1'b1;
                        fail.phase = phase_of(state);
                    end
                end
                ST_FIRST, ST_NEXT: begin
                    if (evt.data) begin
                        nxt     = evt.last ? ST_STATUS : ST_NEXT;
                        restart = 1'b1;
                    end else if (expire) begin
                        nxt        = ST_IDLE;
                        fail.valid = 1'b1;
                        fail.phase = phase_of(state);
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/ctw_fail_flag.sv
module ctw_fail_flag
    import ctw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctw_fail_t  fail,
    input  logic       clr,
    output logic       flag,
    output ctw_phase_e code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            code <= PH_NODATA;
        end else if (fail.valid) begin
            // a new failure outranks a clear in the same cycle
            flag <= 1'b1;
            if (!flag || clr) code <= fail.phase;
        end else if (clr) begin
            flag <= 1'b0;
            code <= PH_NODATA;
        end
    end

endmodule

// File: rtl/ctl_xfer_watchdog.sv
module ctl_xfer_watchdog
    import ctw_pkg::*;
#(
    parameter int CLK_PER_MS = 50000,
    parameter int NODATA_MS  = 2,
    parameter int FIRST_MS   = 10,
    parameter int NEXT_MS    = 5,
    parameter int STATUS_MS  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       setup_pulse,
    input  logic       setup_with_data,
    input  logic       data_pulse,
    input  logic       data_is_last,
    input  logic       status_pulse,
    input  logic       ack_wr,
    input  logic       ack_wdata,
    output logic       timeout_flag,
    output logic [1:0] timeout_phase,
    output logic       tracking
);
    localparam int MAX_A  = (NODATA_MS > FIRST_MS) ? NODATA_MS : FIRST_MS;
    localparam int MAX_B  = (NEXT_MS > STATUS_MS) ? NEXT_MS : STATUS_MS;
    localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MS_W   = $clog2(MAX_MS + 1);

    ctw_evt_t        evt;
    ctw_state_e      state;
    ctw_fail_t       fail;
    ctw_phase_e      code;
    logic            restart;
    logic            tmr_expire;
    logic            fail_valid;
    logic [MS_W-1:0] limit_ms;

    assign evt.setup    = setup_pulse;
    assign evt.has_data = setup_with_data;
    assign evt.data     = data_pulse;
    assign evt.last     = data_is_last;
    assign evt.status   = status_pulse;

    always_comb begin
        case (phase_of(state))
            PH_FIRST:  limit_ms = MS_W'(FIRST_MS);
            PH_NEXT:   limit_ms = MS_W'(NEXT_MS);
            PH_STATUS: limit_ms = MS_W'(STATUS_MS);
            default:   limit_ms = MS_W'(NODATA_MS);
        endcase
    end

    ctw_ms_timer #(
        .CLK_PER_MS(CLK_PER_MS),
        .MS_W      (MS_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state != ST_IDLE),
        .restart (restart),
        .limit_ms(limit_ms),
        .expire  (tmr_expire)
    );

    ctw_phase_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .expire (tmr_expire),
        .state  (state),
        .restart(restart),
        .fail   (fail)
    );

    ctw_fail_flag u_flag (
        .clk (clk),
        .rst (rst),
        .fail(fail),
        .clr (ack_wr && ack_wdata),
        .flag(timeout_flag),
        .code(code)
    );

    assign fail_valid    = fail.valid;
    assign timeout_phase = code;
    assign tracking      = (state != ST_IDLE);

endmodule

// File: rtl/ctw_checker.sv
module ctw_checker (
    input logic       clk,
    input logic       rst,
    input logic       setup_pulse,
    input logic       ack_wr,
    input logic       ack_wdata,
    input logic       timeout_flag,
    input logic [1:0] timeout_phase,
    input logic       tracking,
    input logic       fail_valid
);
    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (!timeout_flag && !tracking && timeout_phase == 2'd0));

    a_r2_setup_starts: assert property (@(posedge clk) disable iff (rst)
        setup_pulse |=> tracking);

    a_r8_timeout_idles: assert property (@(posedge clk) disable iff (rst)
        (fail_valid && !setup_pulse) |=> !tracking);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && !(ack_wr && ack_wdata)) |=> (timeout_flag && $stable(timeout_phase)));

    a_r10_clear_works: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && ack_wdata && !fail_valid) |=> (!timeout_flag && timeout_phase == 2'd0));

endmodule

bind ctl_xfer_watchdog ctw_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .setup_pulse  (setup_pulse),
    .ack_wr       (ack_wr),
    .ack_wdata    (ack_wdata),
    .timeout_flag (timeout_flag),
    .timeout_phase(timeout_phase),
    .tracking     (tracking),
    .fail_valid   (fail_valid)
);

// File: tb/ctl_xfer_watchdog_tb.sv
module ctl_xfer_watchdog_tb;
    localparam int P = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic setup_pulse = 1'b0, setup_with_data = 1'b0;
    logic data_pulse = 1'b0, data_is_last = 1'b0, status_pulse = 1'b0;
    logic ack_wr = 1'b0, ack_wdata = 1'b0;
    logic       timeout_flag;
    logic [1:0] timeout_phase;
    logic       tracking;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ctl_xfer_watchdog #(.CLK_PER_MS(P)) u_dut (
        .clk(clk), .rst(rst),
        .setup_pulse(setup_pulse), .setup_with_data(setup_with_data),
        .data_pulse(data_pulse), .data_is_last(data_is_last),
        .status_pulse(status_pulse),
        .ack_wr(ack_wr), .ack_wdata(ack_wdata),
        .timeout_flag(timeout_flag), .timeout_phase(timeout_phase),
        .tracking(tracking)
    );

    // row: {has_data, packets, late_step (7 = none), expect_flag, expect_code}
    localparam logic [9:0] ROWS [7] = '{
        {1'b0, 3'd0, 3'd7, 1'b0, 2'd0},
        {1'b0, 3'd0, 3'd0, 1'b1, 2'd0},
        {1'b1, 3'd1, 3'd7, 1'b0, 2'd0},
        {1'b1, 3'd3, 3'd7, 1'b0, 2'd0},
        {1'b1, 3'd1, 3'd0, 1'b1, 2'd1},
        {1'b1, 3'd3, 3'd2, 1'b1, 2'd2},
        {1'b1, 3'd2, 3'd2, 1'b1, 2'd3}
    };

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_setup(bit hd);
        @(negedge clk); setup_pulse = 1'b1; setup_with_data = hd;
        @(negedge clk); setup_pulse = 1'b0; setup_with_data = 1'b0;
    endtask

    task automatic do_data(bit last);
        @(negedge clk); data_pulse = 1'b1; data_is_last = last;
        @(negedge clk); data_pulse = 1'b0; data_is_last = 1'b0;
    endtask

    task automatic do_status();
        @(negedge clk); status_pulse = 1'b1;
        @(negedge clk); status_pulse = 1'b0;
    endtask

    task automatic do_ack(bit v);
        @(negedge clk); ack_wr = 1'b1; ack_wdata = v;
        @(negedge clk); ack_wr = 1'b0; ack_wdata = 1'b0;
    endtask

    function automatic int lim(bit hd, int s, int np);
        if (!hd) return 2 * P;
        if (s == 0) return 10 * P;
        if (s < np) return 5 * P;
        return 2 * P;
    endfunction

    function automatic string req_of(int code);
        case (code)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "flag after reset", timeout_flag, 0);
        chk("R1", "phase after reset", timeout_phase, 0);
        chk("R1", "tracking after reset", tracking, 0);

        // table walk: every on-time event lands exactly on its budget edge (R7)
        for (int r = 0; r < 7; r++) begin
            bit hd    = ROWS[r][9];
            int np    = int'(ROWS[r][8:6]);
            int late  = int'(ROWS[r][5:3]);
            bit eflag = ROWS[r][2];
            int ecode = int'(ROWS[r][1:0]);
            int nsteps = hd ? np + 1 : 1;
            bit stop = 1'b0;
            do_setup(hd);
            chk("R2", "tracking after setup", tracking, 1);
            for (int s = 0; s < nsteps; s++) begin
                int L = lim(hd, s, np);
                if (!stop) begin
                    if (s == late) begin
                        repeat (L - 1) @(negedge clk);
                        chk("R7", "flag one edge before budget", timeout_flag, 0);
                        @(negedge clk);
                        chk(req_of(ecode), "flag at budget", timeout_flag, 1);
                        chk(req_of(ecode), "phase code", timeout_phase, ecode);
                        chk("R8", "tracking after timeout", tracking, 0);
                        stop = 1'b1;
                    end else begin
                        repeat (L - 2) @(negedge clk);
                        if (!hd || s == np) do_status();
                        else do_data(s == np - 1);
                    end
                end
            end
            if (!eflag) begin
                chk("R7", "no flag when on budget edge", timeout_flag, 0);
                chk(hd ? "R6" : "R3", "tracking after status", tracking, 0);
                repeat (3 * P) @(negedge clk);
                chk("R7", "still no flag later", timeout_flag, 0);
            end else begin
                do_ack(1'b1);
                chk("R10", "flag cleared", timeout_flag, 0);
            end
        end

        // R2: a new setup mid-transfer swaps in the no-data budget
        do_setup(1'b1);
        repeat (68) @(negedge clk);
        do_setup(1'b0);
        repeat (2 * P - 1) @(negedge clk);
        chk("R2", "no flag before restarted budget", timeout_flag, 0);
        chk("R2", "still tracking", tracking, 1);
        @(negedge clk);
        chk("R2", "flag at restarted budget", timeout_flag, 1);
        chk("R2", "code of restarted phase", timeout_phase, 0);

        // R10: writing zero has no effect
        do_ack(1'b0);
        chk("R10", "flag kept on zero write", timeout_flag, 1);
        chk("R10", "code kept on zero write", timeout_phase, 0);

        // R9: second failure does not overwrite the first code
        do_setup(1'b1);
        repeat (10 * P) @(negedge clk);
        chk("R9", "flag still set", timeout_flag, 1);
        chk("R9", "first code retained", timeout_phase, 0);
        chk("R8", "idle after second timeout", tracking, 0);
        do_ack(1'b1);
        chk("R10", "flag cleared", timeout_flag, 0);
        chk("R10", "code cleared", timeout_phase, 0);

        // R8: stray pulses while idle
        do_data(1'b1);
        do_status();
        @(negedge clk);
        chk("R8", "idle ignores pulses", tracking, 0);
        chk("R8", "no flag from stray pulses", timeout_flag, 0);

        // R8: status during data stage leaves first-data budget untouched
        do_setup(1'b1);
        repeat (18) @(negedge clk);
        do_status();
        repeat (59) @(negedge clk);
        chk("R8", "tracking despite status", tracking, 1);
        chk("R8", "no flag one edge before budget", timeout_flag, 0);
        @(negedge clk);
        chk("R8", "flag at original budget", timeout_flag, 1);
        chk("R4", "first-data code", timeout_phase, 1);
        do_ack(1'b1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule